// File: doc/BRIEF.md
# Five-Port Wormhole Mesh Router

This block switches fixed-length packets at one node of a two-dimensional mesh. It has five ports, each with an input and an output side: four toward neighbouring nodes (north, south, east, west) and one toward the node itself. Every link uses a data word, a valid bit from the sender and a stop bit from the receiver. A flit moves on a clock edge only when valid is high and stop is low.

Each input has a small FIFO. The first two flits of a packet give the destination column and row. The input compares them with the router's own coordinates and picks an output. It corrects the column first and then the row. Each output has a round-robin arbiter. Once a packet wins an output, that output belongs to the packet until its last flit has left. Packets that lose wait in their FIFOs, and their requests stay raised. The header flits travel on with the packet unchanged. Each output is registered, so a flit held by a downstream stop keeps its value.

Top module: `mesh_router`

## Requirements
- R1: After reset no output is valid, every input stop is low, and all FIFOs, output locks and arbiter pointers are cleared.
- R2: A flit crosses a link only in a cycle where valid is high and stop is low. While an output is valid and its stop is high, the output's valid and data stay unchanged.
- R3: An input raises its stop when its FIFO has one or fewer free entries, that is, when it holds FIFO_DEPTH-1 flits. No accepted flit is lost or overwritten. When an output is stalled, a depth-4 input holds exactly 4 flits of the packet: 3 in its FIFO and 1 in the output register.
- R4: Routing is column first, then row. Flit 0 is the destination X and flit 1 is the destination Y, each compared as an unsigned word. If X > MY_X the packet goes to east (port 3). If X < MY_X it goes to west (port 4). Otherwise, if Y > MY_Y it goes to north (port 1), and if Y < MY_Y it goes to south (port 2). When both match it goes to local (port 0).
- R5: Each packet leaves with exactly PKT_LEN flits, in arrival order, with both header flits unchanged.
- R6: Once an output is granted, all PKT_LEN flits of that packet leave it back to back, with no flit from another packet in between.
- R7: When several inputs want the same free output, the grant goes to the first requester at or after the pointer, counting upward modulo 5. The pointer then moves to the index after the winner. It changes only on a new grant. Losing inputs keep requesting and are served later.
- R8: Packets bound for different outputs move at the same time. Three disjoint packets all finish within PKT_LEN+8 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 5*DW | Input flit of each port; port p occupies bits p*DW +: DW |
| in_valid | input | 5 | Sender has a flit on the input |
| in_stop | output | 5 | Router asks the upstream sender to pause |
| out_data | output | 5*DW | Registered output flit of each port |
| out_valid | output | 5 | Output register holds a flit |
| out_stop | input | 5 | Downstream receiver asks the router to pause |

Port index order is local 0, north 1, south 2, east 3, west 4.

## Verification
Several functions can fall in the same cycle: arbitration for one output, and flit transfers on other outputs. The contention tests start several packets on the same negative edge, so their headers complete in the same cycle and the requests collide. The bench judges the result by the exact order of whole packets on the shared output. A second case puts a downstream stall together with the filling of the upstream FIFO. The bench judges it by the flit count the sender got accepted, by the raised input stop, and by the frozen output word. A last case starts three disjoint packets at once and bounds their total completion time, so the transfers must overlap.

// File: rtl/router_pkg.sv
package router_pkg;
  localparam int NUM_PORTS = 5;

  typedef enum logic [2:0] {
    PORT_LOCAL = 3'd0,
    PORT_NORTH = 3'd1,
    PORT_SOUTH = 3'd2,
    PORT_EAST  = 3'd3,
    PORT_WEST  = 3'd4
  } port_e;
endpackage

// File: rtl/router_in_unit.sv
module router_in_unit
  import router_pkg::*;
#(
  parameter int DW      = 16,
  parameter int DEPTH   = 4,
  parameter int PKT_LEN = 8,
  parameter int MY_X    = 0,
  parameter int MY_Y    = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] in_data,
  input  logic          in_valid,
  output logic          in_stop,
  input  logic          pop,
  input  logic          granted,
  output logic [DW-1:0] head,
  output logic          has_flit,
  output logic          req,
  output port_e         route,
  output logic          last
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = (PKT_LEN > 1) ? $clog2(PKT_LEN) : 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic [PW-1:0] fcnt;
  logic          busy;
  logic          wr;
  logic [DW-1:0] dst_y;

  assign in_stop  = (count >= CW'(DEPTH - 1));
  assign wr       = in_valid && !in_stop;
  assign head     = mem[rd_ptr];
  assign dst_y    = mem[rd_ptr + AW'(1)];
  assign has_flit = (count != '0);
  assign last     = (fcnt == PW'(PKT_LEN - 1));
  assign req      = !busy && (fcnt == '0) && (count >= CW'(2));

  // storage without reset so it can map to RAM
  always_ff @(posedge clk) begin
    if (wr) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      fcnt   <= '0;
      busy   <= 1'b0;
    end else begin
      if (wr)  wr_ptr <= wr_ptr + AW'(1);
      if (pop) rd_ptr <= rd_ptr + AW'(1);
      case ({wr, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
      if (pop) fcnt <= last ? '0 : fcnt + PW'(1);
      if (granted)          busy <= 1'b1;
      else if (pop && last) busy <= 1'b0;
    end
  end

  // column first, then row
  always_comb begin
    if (head > DW'(MY_X))       route = PORT_EAST;
    else if (head < DW'(MY_X))  route = PORT_WEST;
    else if (dst_y > DW'(MY_Y)) route = PORT_NORTH;
    else if (dst_y < DW'(MY_Y)) route = PORT_SOUTH;
    else                        route = PORT_LOCAL;
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH - 1));
  p_pop_nonempty_r2: assert property (@(posedge clk) disable iff (rst)
    pop |-> has_flit);
  p_req_held_r7: assert property (@(posedge clk) disable iff (rst)
    (req && !granted) |=> (req && $stable(route)));
endmodule

// File: rtl/router_out_unit.sv
module router_out_unit #(
  parameter int DW = 16,
  parameter int NP = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NP-1:0]  req,
  input  logic [NP*DW-1:0] head_data,
  input  logic [NP-1:0]  has_flit,
  input  logic [NP-1:0]  last,
  input  logic           out_stop,
  output logic [DW-1:0]  out_data,
  output logic           out_valid,
  output logic [NP-1:0]  grant,
  output logic [NP-1:0]  pop
);
  localparam int IW = $clog2(NP);

  logic          locked;
  logic [IW-1:0] owner, ptr, gsel;
  logic          gany, load;

  always_comb begin
    int j;
    gsel = '0;
    gany = 1'b0;
    for (int k = 0; k < NP; k++) begin
      j = int'(ptr) + k;
      if (j >= NP) j = j - NP;
      if (!gany && req[j]) begin
        gany = 1'b1;
        gsel = IW'(j);
      end
    end
  end

  assign load = locked && has_flit[owner] && (!out_valid || !out_stop);

  always_comb begin
    grant = '0;
    pop   = '0;
    if (!locked && gany) grant[gsel]  = 1'b1;
    if (load)            pop[owner]   = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      locked    <= 1'b0;
      owner     <= '0;
      ptr       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (!locked && gany) begin
        locked <= 1'b1;
        owner  <= gsel;
        ptr    <= (gsel == IW'(NP - 1)) ? '0 : gsel + IW'(1);
      end else if (load && last[owner]) begin
        locked <= 1'b0;
      end
      if (load) begin
        out_data  <= head_data[int'(owner)*DW +: DW];
        out_valid <= 1'b1;
      end else if (!out_stop) begin
        out_valid <= 1'b0;
      end
    end
  end

  p_grant_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
  p_hold_stalled_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_stop) |=> (out_valid && $stable(out_data)));
  p_lock_kept_r6: assert property (@(posedge clk) disable iff (rst)
    (locked && !(load && last[owner])) |=> (locked && $stable(owner)));
endmodule

// File: rtl/mesh_router.sv
module mesh_router
  import router_pkg::*;
#(
  parameter int DW         = 16,
  parameter int PKT_LEN    = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int MY_X       = 2,
  parameter int MY_Y       = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_PORTS*DW-1:0]  in_data,
  input  logic [NUM_PORTS-1:0]     in_valid,
  output logic [NUM_PORTS-1:0]     in_stop,
  output logic [NUM_PORTS*DW-1:0]  out_data,
  output logic [NUM_PORTS-1:0]     out_valid,
  input  logic [NUM_PORTS-1:0]     out_stop
);
  localparam int NP = NUM_PORTS;

  logic [NP-1:0]    req_i, last_i, has_i, grant_i, pop_i;
  port_e            route_i [NP];
  logic [NP*DW-1:0] head_flat;
  logic [NP-1:0]    req_o   [NP];
  logic [NP-1:0]    grant_o [NP];
  logic [NP-1:0]    pop_o   [NP];

  for (genvar i = 0; i < NP; i++) begin : g_in
    router_in_unit #(
      .DW(DW), .DEPTH(FIFO_DEPTH), .PKT_LEN(PKT_LEN), .MY_X(MY_X), .MY_Y(MY_Y)
    ) u_in (
      .clk      (clk),
      .rst      (rst),
      .in_data  (in_data[i*DW +: DW]),
      .in_valid (in_valid[i]),
      .in_stop  (in_stop[i]),
      .pop      (pop_i[i]),
      .granted  (grant_i[i]),
      .head     (head_flat[i*DW +: DW]),
      .has_flit (has_i[i]),
      .req      (req_i[i]),
      .route    (route_i[i]),
      .last     (last_i[i])
    );
  end

  always_comb begin
    for (int o = 0; o < NP; o++)
      for (int i = 0; i < NP; i++)
        req_o[o][i] = req_i[i] && (route_i[i] == port_e'(o));
  end

  always_comb begin
    grant_i = '0;
    pop_i   = '0;
    for (int o = 0; o < NP; o++) begin
      grant_i = grant_i | grant_o[o];
      pop_i   = pop_i | pop_o[o];
    end
  end

  for (genvar o = 0; o < NP; o++) begin : g_out
    router_out_unit #(.DW(DW), .NP(NP)) u_out (
      .clk       (clk),
      .rst       (rst),
      .req       (req_o[o]),
      .head_data (head_flat),
      .has_flit  (has_i),
      .last      (last_i),
      .out_stop  (out_stop[o]),
      .out_data  (out_data[o*DW +: DW]),
      .out_valid (out_valid[o]),
      .grant     (grant_o[o]),
      .pop       (pop_o[o])
    );
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (out_valid == '0 && in_stop == '0));
endmodule

// File: tb/mesh_router_tb.sv
`timescale 1ns/1ps
module mesh_router_tb;
  localparam int DW = 16;
  localparam int NP = 5;
  localparam int PL = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DW-1:0] din [NP];
  logic [NP-1:0] vin = '0;
  logic [NP-1:0] out_stop = '0;
  logic [NP*DW-1:0] in_data, out_data;
  logic [NP-1:0] in_stop, out_valid;

  logic [DW-1:0] cap [NP][$];
  logic [DW-1:0] expq [NP][$];
  int acc_cnt [NP];
  int checks = 0, fails = 0, cyc = 0;
  bit tog_en = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always_comb for (int p = 0; p < NP; p++) in_data[p*DW +: DW] = din[p];

  mesh_router #(.DW(DW), .PKT_LEN(PL), .FIFO_DEPTH(4), .MY_X(2), .MY_Y(2)) u_dut (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(vin), .in_stop(in_stop),
    .out_data(out_data), .out_valid(out_valid), .out_stop(out_stop));

  always @(negedge clk) if (tog_en) out_stop[3] = ~out_stop[3];

  always @(negedge clk) begin
    #1;
    if (!rst)
      for (int o = 0; o < NP; o++)
        if (out_valid[o] && !out_stop[o]) cap[o].push_back(out_data[o*DW +: DW]);
  end

  function automatic logic [DW-1:0] mkflit(int src, int id, int k, int x, int y);
    if (k == 0) return DW'(x);
    if (k == 1) return DW'(y);
    return {src[3:0], id[3:0], k[7:0]};
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic send_pkt(int p, int id, int x, int y);
    bit acc;
    for (int k = 0; k < PL; k++) begin
      din[p] = mkflit(p, id, k, x, y);
      vin[p] = 1'b1;
      do begin
        acc = !in_stop[p];
        @(negedge clk);
      end while (!acc);
      acc_cnt[p]++;
    end
    vin[p] = 1'b0;
  endtask

  task automatic push_exp(int o, int src, int id, int x, int y);
    for (int k = 0; k < PL; k++) expq[o].push_back(mkflit(src, id, k, x, y));
  endtask

  task automatic check_port(int o, string req);
    int bad = -1;
    if (cap[o].size() == expq[o].size()) begin
      for (int k = 0; k < cap[o].size(); k++)
        if (bad < 0 && cap[o][k] !== expq[o][k]) bad = k;
    end else bad = 0;
    if (bad >= 0 && cap[o].size() == expq[o].size())
      check(1'b0, req, $sformatf("port %0d flit %0d", o, bad), int'(cap[o][bad]), int'(expq[o][bad]));
    else
      check(bad < 0, req, $sformatf("port %0d flit count", o), cap[o].size(), expq[o].size());
    cap[o].delete();
    expq[o].delete();
  endtask

  task automatic drain();
    repeat (60) @(negedge clk);
  endtask

  task automatic t_reset();
    check(out_valid == '0, "R1", "out_valid after reset", int'(out_valid), 0);
    check(in_stop == '0, "R1", "in_stop after reset", int'(in_stop), 0);
  endtask

  // R4 R5: one packet at a time from the local input
  task automatic t_routing();
    int dx [6] = '{3, 1, 2, 2, 2, 3};
    int dy [6] = '{2, 2, 3, 1, 2, 0};
    int po [6] = '{3, 4, 1, 2, 0, 3};
    for (int n = 0; n < 6; n++) begin
      push_exp(po[n], 0, n, dx[n], dy[n]);
      send_pkt(0, n, dx[n], dy[n]);
      drain();
      check_port(po[n], "R4");
    end
  endtask

  // R7 R6: contention on the local output (pointer is 1 here)
  task automatic t_contention();
    push_exp(0, 4, 1, 2, 2);
    push_exp(0, 0, 2, 2, 2);
    fork
      send_pkt(0, 2, 2, 2);
      send_pkt(4, 1, 2, 2);
    join
    drain();
    check_port(0, "R7");
    for (int s = 1; s <= 4; s++) push_exp(0, s, 5, 2, 2);
    push_exp(0, 0, 5, 2, 2);
    fork
      send_pkt(0, 5, 2, 2);
      send_pkt(1, 5, 2, 2);
      send_pkt(2, 5, 2, 2);
      send_pkt(3, 5, 2, 2);
      send_pkt(4, 5, 2, 2);
    join
    drain();
    check_port(0, "R6");
  endtask

  // R2 R3: stalled output fills the input FIFO
  task automatic t_backpressure();
    acc_cnt[4] = 0;
    out_stop[0] = 1'b1;
    push_exp(0, 4, 7, 2, 2);
    fork
      send_pkt(4, 7, 2, 2);
      begin
        repeat (20) @(negedge clk);
        check(acc_cnt[4] == 4, "R3", "flits accepted while stalled", acc_cnt[4], 4);
        check(in_stop[4] == 1'b1, "R3", "in_stop while stalled", int'(in_stop[4]), 1);
        check(out_valid[0] == 1'b1, "R2", "out_valid held", int'(out_valid[0]), 1);
        check(out_data[0 +: DW] == 16'd2, "R2", "held header", int'(out_data[0 +: DW]), 2);
        check(cap[0].size() == 0, "R2", "no transfer under stop", cap[0].size(), 0);
        out_stop[0] = 1'b0;
      end
    join
    drain();
    check_port(0, "R5");
    push_exp(3, 0, 9, 3, 2);
    tog_en = 1'b1;
    send_pkt(0, 9, 3, 2);
    drain();
    tog_en = 1'b0;
    @(negedge clk);
    out_stop[3] = 1'b0;
    drain();
    check_port(3, "R2");
  endtask

  // R8: disjoint paths in parallel
  task automatic t_parallel();
    int t0;
    int t1;
    push_exp(4, 3, 10, 1, 2);
    push_exp(3, 4, 11, 3, 2);
    push_exp(1, 0, 12, 2, 3);
    @(negedge clk);
    t0 = cyc;
    fork
      send_pkt(3, 10, 1, 2);
      send_pkt(4, 11, 3, 2);
      send_pkt(0, 12, 2, 3);
    join
    for (int w = 0; w < 40; w++) begin
      if (cap[4].size() == PL && cap[3].size() == PL && cap[1].size() == PL) break;
      @(negedge clk);
    end
    t1 = cyc;
    check((t1 - t0) <= PL + 8, "R8", "parallel completion cycles", t1 - t0, PL + 8);
    drain();
    check_port(4, "R8");
    check_port(3, "R8");
    check_port(1, "R5");
  endtask

  initial begin
    for (int p = 0; p < NP; p++) begin
      din[p] = '0;
      acc_cnt[p] = 0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_routing();
    t_contention();
    t_backpressure();
    t_parallel();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule